// File: doc/BRIEF.md
# Dual-Address Transfer Sequencer

This block runs one channel's block move as a series of dual-address operand transfers. A start strobe loads a source pointer, a destination pointer, a byte count, the two operand-size codes and the two pointer-step enables. After that the block repeats a fixed cycle. It reads one operand from the source pointer into a single-operand holding register. It then writes that operand to the destination pointer. This continues until the byte count is used up.

The block talks to a simple bus. `bus_req` together with `bus_we` opens an address phase. `bus_aack` tells the block that the arbiter accepted the address, and `bus_dack` ends the data phase. An arbiter that holds a request off simply leaves `bus_aack` low. While that happens, nothing inside the sequencer moves.

The states are IDLE, RD_ADDR, RD_DATA, WR_ADDR, WR_DATA and FINISH, with these transitions:
- IDLE→RD_ADDR on start with a non-zero count.
- IDLE→FINISH on start with a zero count.
- RD_ADDR→RD_DATA on `bus_aack`.
- RD_DATA→WR_ADDR on `bus_dack`.
- WR_ADDR→WR_DATA on `bus_aack`.
- WR_DATA→RD_ADDR on `bus_dack` while bytes remain.
- WR_DATA→FINISH on `bus_dack` once the count is zero.
- FINISH→IDLE unconditionally.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done` and `bus_req` are low.
- R2: A start strobe in IDLE with a non-zero count latches all set-up inputs. The read address phase begins on the next cycle with `bus_addr` equal to the loaded source pointer.
- R3: Size codes are 00 = 4 bytes, 01 = 1 byte, 10 = 2 bytes and 11 = 16 bytes. The step is the larger of the two decoded sizes, and `bus_size` presents the code of that larger size during the transfer.
- R4: The source pointer advances by the step only when a read address phase is accepted, and only if `src_step_en` was set at start. Otherwise it stays at its start value for the whole block.
- R5: The destination pointer advances by the step only when a write address phase is accepted, and only if `dst_step_en` was set at start. Otherwise it stays at its start value.
- R6: While `bus_req` is high and `bus_aack` is low, `bus_addr`, `bus_we` and `bus_req` hold, and no pointer or count changes.
- R7: Each operand follows a fixed order. First a read address phase (`bus_we`=0). Then a read data phase with `bus_req` low, in which `bus_rdata` is captured on `bus_dack`. Then a write address phase (`bus_we`=1). Then a write data phase in which the captured value is driven on `bus_wdata`.
- R8: The byte count drops by the step only when a write address phase is accepted, and it stops at zero. The number of operands moved is the count divided by the step, rounded up.
- R9: When a write data phase ends with the count at zero, `done` is high for exactly one cycle (FINISH), and the block then returns to IDLE.
- R10: A start strobe with a zero count goes straight to FINISH with no bus request.
- R11: A start strobe while `busy` is high is ignored, and the running block keeps its pointers and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, honoured in IDLE only |
| src_addr_in | input | AW | Source start address (any byte) |
| dst_addr_in | input | AW | Destination start address (any byte) |
| byte_cnt_in | input | CW | Bytes to move |
| src_size | input | 2 | Source operand size code |
| dst_size | input | 2 | Destination operand size code |
| src_step_en | input | 1 | Advance source pointer per operand |
| dst_step_en | input | 1 | Advance destination pointer per operand |
| bus_req | output | 1 | Address phase request |
| bus_we | output | 1 | 1 = write phase, 0 = read phase |
| bus_addr | output | AW | Address of the current phase |
| bus_size | output | 2 | Operand size code of the transfer |
| bus_aack | input | 1 | Address accepted by the arbiter |
| bus_dack | input | 1 | Data phase complete |
| bus_rdata | input | DW | Read data |
| bus_wdata | output | DW | Write data (held operand) |
| busy | output | 1 | Channel active |
| done | output | 1 | One-cycle completion pulse |

## Verification
The tests use several set-ups:
- Same-size pairs, which show plain pointer stepping.
- Mixed sizes in both orders, which show that the larger size wins rather than the source or the destination size.
- A line-sized pair, which checks the 16-byte step.
- Runs with one step enable cleared, which show that the two pointers step independently.
- Counts that are not a multiple of the step, which expose whether the count stops at zero and how many operands are moved.

Arbiter hold-off cycles are inserted so that a pointer that advanced on request rather than on acceptance would show up at the next address. Separate directed cases cover a zero count and a start strobe raised in the middle of a block.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int STEP_W = 5;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_RD_ADDR = 3'd1,
        S_RD_DATA = 3'd2,
        S_WR_ADDR = 3'd3,
        S_WR_DATA = 3'd4,
        S_FINISH  = 3'd5
    } seq_state_t;

    function automatic logic [STEP_W-1:0] code_bytes(input logic [1:0] code);
        unique case (code)
            2'b00:   code_bytes = 5'd4;
            2'b01:   code_bytes = 5'd1;
            2'b10:   code_bytes = 5'd2;
            default: code_bytes = 5'd16;
        endcase
    endfunction

    function automatic logic [1:0] wider_code(input logic [1:0] a, input logic [1:0] b);
        wider_code = (code_bytes(a) >= code_bytes(b)) ? a : b;
    endfunction

endpackage

// File: rtl/dma_addr_reg.sv
module dma_addr_reg #(
    parameter int AW = 32,
    parameter int SW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step_en_in,
    input  logic          adv,
    input  logic [SW-1:0] step,
    output logic [AW-1:0] addr
);
    logic step_en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr      <= '0;
            step_en_q <= 1'b0;
        end else if (load) begin
            addr      <= load_val;
            step_en_q <= step_en_in;
        end else if (adv && step_en_q) begin
            addr      <= addr + AW'(step);
        end
    end
endmodule

// File: rtl/dma_byte_cnt.sv
module dma_byte_cnt #(
    parameter int CW = 16,
    parameter int SW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    input  logic [SW-1:0] step,
    output logic [CW-1:0] cnt,
    output logic          zero
);
    logic [CW-1:0] step_w;

    assign step_w = CW'(step);
    assign zero   = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= (cnt > step_w) ? (cnt - step_w) : '0;
        end
    end
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       load_cnt_zero,
    input  logic       cnt_zero,
    input  logic       aack,
    input  logic       dack,
    output seq_state_t state,
    output logic       req,
    output logic       we,
    output logic       load,
    output logic       src_adv,
    output logic       dst_adv,
    output logic       cnt_dec,
    output logic       cap,
    output logic       busy,
    output logic       done
);
    seq_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (start) nxt = load_cnt_zero ? S_FINISH : S_RD_ADDR;
            S_RD_ADDR: if (aack)  nxt = S_RD_DATA;
            S_RD_DATA: if (dack)  nxt = S_WR_ADDR;
            S_WR_ADDR: if (aack)  nxt = S_WR_DATA;
            S_WR_DATA: if (dack)  nxt = cnt_zero ? S_FINISH : S_RD_ADDR;
            S_FINISH:             nxt = S_IDLE;
            default:              nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        req     = 1'b0;
        we      = 1'b0;
        load    = 1'b0;
        src_adv = 1'b0;
        dst_adv = 1'b0;
        cnt_dec = 1'b0;
        cap     = 1'b0;
        busy    = 1'b1;
        done    = 1'b0;
        unique case (state)
            S_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            S_RD_ADDR: begin
                req     = 1'b1;
                src_adv = aack;
            end
            S_RD_DATA: cap = dack;
            S_WR_ADDR: begin
                req     = 1'b1;
                we      = 1'b1;
                dst_adv = aack;
                cnt_dec = aack;
            end
            S_WR_DATA: we = 1'b1;
            S_FINISH:  done = 1'b1;
            default:   busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dma_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] src_addr_in,
    input  logic [AW-1:0] dst_addr_in,
    input  logic [CW-1:0] byte_cnt_in,
    input  logic [1:0]    src_size,
    input  logic [1:0]    dst_size,
    input  logic          src_step_en,
    input  logic          dst_step_en,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    input  logic          bus_aack,
    input  logic          bus_dack,
    input  logic [DW-1:0] bus_rdata,
    output logic [DW-1:0] bus_wdata,
    output logic          busy,
    output logic          done
);
    seq_state_t        state;
    logic              load, src_adv, dst_adv, cnt_dec, cap, cnt_zero;
    logic [1:0]        size_q;
    logic [STEP_W-1:0] step;
    logic [AW-1:0]     src_q, dst_q;
    logic [CW-1:0]     cnt_q;
    logic [DW-1:0]     data_q;

    dma_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .load_cnt_zero(byte_cnt_in == '0), .cnt_zero(cnt_zero),
        .aack(bus_aack), .dack(bus_dack), .state(state),
        .req(bus_req), .we(bus_we), .load(load),
        .src_adv(src_adv), .dst_adv(dst_adv), .cnt_dec(cnt_dec),
        .cap(cap), .busy(busy), .done(done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q <= 2'b01;
            data_q <= '0;
        end else begin
            if (load) size_q <= wider_code(src_size, dst_size);
            if (cap)  data_q <= bus_rdata;
        end
    end

    assign step = code_bytes(size_q);

    dma_addr_reg #(.AW(AW), .SW(STEP_W)) u_src (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(src_addr_in),
        .step_en_in(src_step_en), .adv(src_adv), .step(step), .addr(src_q)
    );

    dma_addr_reg #(.AW(AW), .SW(STEP_W)) u_dst (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(dst_addr_in),
        .step_en_in(dst_step_en), .adv(dst_adv), .step(step), .addr(dst_q)
    );

    dma_byte_cnt #(.CW(CW), .SW(STEP_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(byte_cnt_in),
        .dec(cnt_dec), .step(step), .cnt(cnt_q), .zero(cnt_zero)
    );

    assign bus_addr  = bus_we ? dst_q : src_q;
    assign bus_size  = size_q;
    assign bus_wdata = data_q;
endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic          bus_aack,
    input logic          busy,
    input logic          done,
    input logic [AW-1:0] src_q,
    input logic [AW-1:0] dst_q,
    input logic [CW-1:0] cnt_q
);
    a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    a_r6_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_aack |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                                  && $stable(src_q) && $stable(dst_q) && $stable(cnt_q));

    a_r7_data_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_aack |=> !bus_req && busy);

    a_r8_cnt_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !(bus_req && bus_we && bus_aack) |=> $stable(cnt_q));

    a_r4_src_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !(bus_req && !bus_we && bus_aack) |=> $stable(src_q));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);
endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_aack(bus_aack), .busy(busy), .done(done),
    .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q)
);

// File: tb/test_dma_xfer_seq.sv
module test_dma_xfer_seq;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 16;

    typedef struct packed {
        logic [31:0] s;
        logic [31:0] d;
        logic [15:0] n;
        logic [1:0]  ss;
        logic [1:0]  ds;
        logic        si;
        logic        di;
        logic [1:0]  holds;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VT [NV] = '{
        '{32'h0000_1000, 32'h0000_2000, 16'd8,  2'b01, 2'b01, 1'b1, 1'b1, 2'd0},
        '{32'h0000_1001, 32'h0000_3003, 16'd6,  2'b10, 2'b01, 1'b1, 1'b0, 2'd1},
        '{32'h0000_4000, 32'h0000_5002, 16'd12, 2'b00, 2'b10, 1'b0, 1'b1, 2'd2},
        '{32'h0000_0100, 32'h0000_0200, 16'd32, 2'b11, 2'b00, 1'b1, 1'b1, 2'd0},
        '{32'h0000_0007, 32'h0000_0009, 16'd5,  2'b01, 2'b00, 1'b1, 1'b1, 2'd1},
        '{32'h0000_0010, 32'h0000_0020, 16'd3,  2'b01, 2'b11, 1'b1, 1'b1, 2'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] src_addr_in = '0, dst_addr_in = '0;
    logic [CW-1:0] byte_cnt_in = '0;
    logic [1:0]    src_size = 2'b01, dst_size = 2'b01;
    logic          src_step_en = 1'b0, dst_step_en = 1'b0;
    logic          bus_req, bus_we, busy, done;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_size;
    logic          bus_aack = 1'b0, bus_dack = 1'b0;
    logic [DW-1:0] bus_rdata = '0, bus_wdata;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dma_xfer_seq #(.AW(AW), .DW(DW), .CW(CW)) i_dma_xfer_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_addr_in(src_addr_in), .dst_addr_in(dst_addr_in), .byte_cnt_in(byte_cnt_in),
        .src_size(src_size), .dst_size(dst_size),
        .src_step_en(src_step_en), .dst_step_en(dst_step_en),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_aack(bus_aack), .bus_dack(bus_dack), .bus_rdata(bus_rdata),
        .bus_wdata(bus_wdata), .busy(busy), .done(done)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp,
                       input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] c);
        case (c)
            2'b00:   return 4;
            2'b01:   return 1;
            2'b10:   return 2;
            default: return 16;
        endcase
    endfunction

    task automatic run_xfer(input vec_t v, input int idx, input bit poke);
        int step, ops;
        logic [1:0]  ecode;
        logic [31:0] es, ed, pat;
        ecode = (nbytes(v.ss) >= nbytes(v.ds)) ? v.ss : v.ds;
        step  = nbytes(ecode);
        ops   = (int'(v.n) + step - 1) / step;
        @(negedge clk);
        src_addr_in = v.s; dst_addr_in = v.d; byte_cnt_in = v.n;
        src_size = v.ss; dst_size = v.ds; src_step_en = v.si; dst_step_en = v.di;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        es = v.s; ed = v.d;
        for (int k = 0; k < ops; k++) begin
            pat = 32'h5A00_0000 ^ (idx << 16) ^ k;
            chk(bus_req, 1, "R2", "read request");
            chk(bus_we, 0, "R7", "read direction");
            chk(bus_addr, es, "R4", "source address");
            chk(bus_size, ecode, "R3", "size code");
            for (int h = 0; h < int'(v.holds); h++) begin
                @(negedge clk);
                chk(bus_req, 1, "R6", "read held");
                chk(bus_addr, es, "R6", "read addr held");
            end
            bus_aack = 1'b1; @(negedge clk); bus_aack = 1'b0;
            chk(bus_req, 0, "R7", "read data phase");
            if (poke && k == 0) begin
                src_addr_in = 32'hDEAD_0000; dst_addr_in = 32'hBEEF_0000;
                byte_cnt_in = 16'd1; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                chk(busy, 1, "R11", "busy after stray start");
                chk(bus_req, 0, "R11", "stray start no effect");
            end
            bus_rdata = pat; bus_dack = 1'b1; @(negedge clk);
            bus_dack = 1'b0; bus_rdata = '0;
            chk(bus_req, 1, "R7", "write request");
            chk(bus_we, 1, "R7", "write direction");
            chk(bus_addr, ed, "R5", "destination address");
            for (int h = 0; h < int'(v.holds); h++) begin
                @(negedge clk);
                chk(bus_addr, ed, "R6", "write addr held");
            end
            bus_aack = 1'b1; @(negedge clk); bus_aack = 1'b0;
            chk(bus_req, 0, "R7", "write data phase");
            chk(bus_wdata, pat, "R7", "write data");
            bus_dack = 1'b1; @(negedge clk); bus_dack = 1'b0;
            if (v.si) es = es + step;
            if (v.di) ed = ed + step;
            if (k < ops - 1) chk(done, 0, "R8", "no early done");
        end
        chk(done, 1, "R9", "done pulse");
        chk(bus_req, 0, "R9", "no request at finish");
        @(negedge clk);
        chk(done, 0, "R9", "done one cycle");
        chk(busy, 0, "R9", "back to idle");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy, 0, "R1", "busy in reset");
        chk(bus_req, 0, "R1", "req in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy, 0, "R1", "busy after reset");
        chk(done, 0, "R1", "done after reset");
        chk(bus_req, 0, "R1", "req after reset");

        for (int i = 0; i < NV; i++) run_xfer(VT[i], i, 1'b0);

        // R11: stray start in the middle of a block
        run_xfer('{32'h0000_0800, 32'h0000_0900, 16'd4, 2'b10, 2'b10, 1'b1, 1'b1, 2'd1}, 7, 1'b1);

        // R10: zero count
        @(negedge clk);
        byte_cnt_in = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done, 1, "R10", "zero count done");
        chk(bus_req, 0, "R10", "zero count no request");
        @(negedge clk);
        chk(busy, 0, "R10", "zero count idle");
        chk(bus_req, 0, "R10", "zero count still quiet");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule